// File: doc/BRIEF.md
# Overlapped Tile Address Generator

This block produces the read address stream for a streaming 3D stencil pipeline that works on a grid in spatial tiles. Each tile covers a square XY footprint of `blk_size` cells a side. The footprint starts `halo` cells before the region the tile computes, so the first tile begins at negative X and Y coordinates. Tiles advance by `blk_size - 2*halo`, which makes neighbours share a band of `halo` cells on each side. Inside one tile the generator walks X fastest, then Y, and then every Z plane before it moves on to the next tile. Tiles are taken left to right, starting at the top-left one, and then row by row.

Grid dimensions, tile size, halo and a padding offset are sampled when `start` is accepted. Grid dimensions may be any size that fits the port width and need not be multiples of the tile step. Every cell that falls outside the grid is marked out-of-bound and carries address zero. A cell inside the grid maps to `pad + (z*dim_y + y)*dim_x + x` in the padded buffer. The padding offset lets the caller align accesses to 512-bit words, which hold 16 elements of 32 bits.

The traversal is one merged loop. Completion is decided by comparing a single global access index with a total count that is computed once when `start` is accepted.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset, `out_valid` and `done` are both low.
- R2: The first access after an accepted `start` is at coordinates (x, y, z) = (-halo, -halo, 0).
- R3: Within a tile, the local X offset runs from 0 to blk_size-1 fastest. Local Y runs from 0 to blk_size-1 next, then Z runs from 0 to dim_z-1. After that comes the next tile in X. After the last tile of a row, the first tile of the next row in Y follows.
- R4: Tile origins in X and Y are `t*(blk_size - 2*halo) - halo`, for tile number t counted from 0.
- R5: `out_oob` is 1 exactly when x<0, x>=dim_x, y<0 or y>=dim_y. An out-of-bound access has `out_addr` = 0.
- R6: An in-bound access has `out_addr` = pad + (z*dim_y + y)*dim_x + x, taken modulo 2^ADDR_W.
- R7: A run emits exactly nbx*nby*dim_z*blk_size² accesses. Here nbx is the number of tile steps needed to cover dim_x, and nby the same for dim_y, so partial tiles at the far edge are allowed.
- R8: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid`, `out_addr` and `out_oob` unchanged.
- R9: `done` is high for exactly one cycle, the cycle after the final access is accepted, and `out_valid` is low in that cycle.
- R10: A `start` arriving while a run is in progress has no effect on the access stream.
- R11: If the total count is zero (dim_z = 0, or blk_size <= 2*halo), `done` pulses in the cycle after `start` and no access is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep with the present configuration (ignored while busy) |
| dim_x | input | DIM_W | Grid size in X |
| dim_y | input | DIM_W | Grid size in Y |
| dim_z | input | DIM_W | Grid size in Z |
| blk_size | input | DIM_W | Tile footprint width in X and Y |
| halo | input | DIM_W | Halo width |
| pad | input | ADDR_W | Padding offset in elements added to every in-bound address |
| out_ready | input | 1 | Downstream accepts the present access |
| out_valid | output | 1 | An access is presented |
| out_addr | output | ADDR_W | Linear element address in the padded buffer |
| out_oob | output | 1 | Access lies outside the grid |
| done | output | 1 | One-cycle pulse after the final access is accepted |

## Verification
The hardest situations to reach are the tile-row transitions that occur while the downstream is stalling. The X origin must return to -halo while Y advances by the step, and a stall at that point must hold the value already presented. Partial far-edge tiles make this harder still. The stimulus uses grids that are not multiples of the step and mixes pseudo-random and alternating ready patterns. A configuration is also injected with `start` in the middle of a run, and the scoreboard, which replays the expected sweep, exposes any disturbance.

// File: rtl/tile_gen_pkg.sv
package tile_gen_pkg;

  // Ceiling division; a zero divisor yields zero tiles.
  function automatic logic [63:0] ceil_div(input logic [63:0] num, input logic [63:0] den);
    if (den == 64'd0) return 64'd0;
    return (num + den - 64'd1) / den;
  endfunction

  // Padded row-major element address.
  function automatic logic [63:0] lin_addr(input logic [63:0] pad, input logic [63:0] z,
                                           input logic [63:0] row, input logic [63:0] col,
                                           input logic [63:0] dx, input logic [63:0] dy);
    return pad + (z * dy + row) * dx + col;
  endfunction

  // True when a signed coordinate lies outside [0, lim).
  function automatic logic outside(input logic signed [63:0] c, input logic [63:0] lim);
    return (c < 64'sd0) || (c >= $signed(lim));
  endfunction

endpackage

// File: rtl/tile_cfg.sv
module tile_cfg
  import tile_gen_pkg::*;
#(
  parameter int DIM_W = 12,
  parameter int CNT_W = 40
) (
  input  logic [DIM_W-1:0] dim_x,
  input  logic [DIM_W-1:0] dim_y,
  input  logic [DIM_W-1:0] dim_z,
  input  logic [DIM_W-1:0] blk,
  input  logic [DIM_W-1:0] halo,
  output logic [DIM_W-1:0] step,
  output logic [DIM_W-1:0] nbx,
  output logic [DIM_W-1:0] nby,
  output logic [CNT_W-1:0] total
);
  logic [DIM_W:0] two_h;
  logic [DIM_W:0] bw;
  logic [63:0]    prod;

  always_comb begin
    two_h = {halo, 1'b0};
    bw    = {1'b0, blk};
    step  = (bw > two_h) ? DIM_W'(bw - two_h) : '0;
    nbx   = DIM_W'(ceil_div(64'(dim_x), 64'(step)));
    nby   = DIM_W'(ceil_div(64'(dim_y), 64'(step)));
    prod  = 64'(nbx) * 64'(nby) * 64'(dim_z) * 64'(blk) * 64'(blk);
    total = CNT_W'(prod);
  end
endmodule

// File: rtl/tile_walker.sv
module tile_walker #(
  parameter int DIM_W = 12,
  localparam int CW   = DIM_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 adv,
  input  logic [DIM_W-1:0]     blk,
  input  logic [DIM_W-1:0]     halo,
  input  logic [DIM_W-1:0]     step,
  input  logic [DIM_W-1:0]     nbx,
  input  logic [DIM_W-1:0]     nby,
  input  logic [DIM_W-1:0]     dim_z,
  output logic signed [CW-1:0] gx,
  output logic signed [CW-1:0] gy,
  output logic [DIM_W-1:0]     gz,
  output logic [DIM_W-1:0]     lx
);
  logic [DIM_W-1:0]     ly, bxc, byc;
  logic signed [CW-1:0] ox, oy, neg_h, stp;
  logic x_wrap, y_wrap, z_wrap, bx_wrap;

  assign neg_h   = -$signed({2'b00, halo});
  assign stp     = $signed({2'b00, step});
  assign x_wrap  = (lx == blk - DIM_W'(1));
  assign y_wrap  = (ly == blk - DIM_W'(1));
  assign z_wrap  = (gz == dim_z - DIM_W'(1));
  assign bx_wrap = (bxc == nbx - DIM_W'(1));
  assign gx      = ox + $signed({2'b00, lx});
  assign gy      = oy + $signed({2'b00, ly});

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      lx <= '0; ly <= '0; gz <= '0; bxc <= '0; byc <= '0;
      ox <= rst_n ? neg_h : '0;
      oy <= rst_n ? neg_h : '0;
    end else if (adv) begin
      lx <= x_wrap ? '0 : lx + DIM_W'(1);
      if (x_wrap) begin
        ly <= y_wrap ? '0 : ly + DIM_W'(1);
        if (y_wrap) begin
          gz <= z_wrap ? '0 : gz + DIM_W'(1);
          if (z_wrap) begin
            if (bx_wrap) begin
              bxc <= '0;
              ox  <= neg_h;
              byc <= byc + DIM_W'(1);
              oy  <= oy + stp;
            end else begin
              bxc <= bxc + DIM_W'(1);
              ox  <= ox + stp;
            end
          end
        end
      end
    end
  end

  // byc only tracks progress; completion is decided by the global index.
  logic unused_byc;
  assign unused_byc = ^{byc, nby};
endmodule

// File: rtl/addr_map.sv
module addr_map
  import tile_gen_pkg::*;
#(
  parameter int DIM_W  = 12,
  parameter int ADDR_W = 32,
  localparam int CW    = DIM_W + 2
) (
  input  logic signed [CW-1:0] gx,
  input  logic signed [CW-1:0] gy,
  input  logic [DIM_W-1:0]     gz,
  input  logic [DIM_W-1:0]     dim_x,
  input  logic [DIM_W-1:0]     dim_y,
  input  logic [ADDR_W-1:0]    pad,
  output logic [ADDR_W-1:0]    addr,
  output logic                 oob
);
  logic signed [63:0] gx64, gy64;

  always_comb begin
    gx64 = {{(64-CW){gx[CW-1]}}, gx};
    gy64 = {{(64-CW){gy[CW-1]}}, gy};
    oob  = outside(gx64, 64'(dim_x)) || outside(gy64, 64'(dim_y));
    addr = oob ? '0 : ADDR_W'(lin_addr(64'(pad), 64'(gz), gy64, gx64,
                                       64'(dim_x), 64'(dim_y)));
  end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int DIM_W  = 12,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  dim_x,
  input  logic [DIM_W-1:0]  dim_y,
  input  logic [DIM_W-1:0]  dim_z,
  input  logic [DIM_W-1:0]  blk_size,
  input  logic [DIM_W-1:0]  halo,
  input  logic [ADDR_W-1:0] pad,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_oob,
  output logic              done
);
  localparam int CW = DIM_W + 2;

  logic              running, done_q;
  logic [CNT_W-1:0]  idx, total_q, total_c;
  logic [DIM_W-1:0]  dx_q, dy_q, dz_q, blk_q, halo_q;
  logic [ADDR_W-1:0] pad_q;
  logic [DIM_W-1:0]  dx_s, dy_s, dz_s, blk_s, halo_s;
  logic [DIM_W-1:0]  step, nbx, nby, gz, lx;
  logic signed [CW-1:0] gx, gy;

  // Named events for the assertions.
  logic accept_start, fire, last_fire;
  assign accept_start = start && !running;
  assign fire         = running && out_ready;
  assign last_fire    = fire && (idx == total_q - CNT_W'(1));

  // Configuration source: live inputs while idle, latched copy while running.
  assign dx_s   = running ? dx_q   : dim_x;
  assign dy_s   = running ? dy_q   : dim_y;
  assign dz_s   = running ? dz_q   : dim_z;
  assign blk_s  = running ? blk_q  : blk_size;
  assign halo_s = running ? halo_q : halo;

  tile_cfg #(.DIM_W(DIM_W), .CNT_W(CNT_W)) u_cfg (
    .dim_x(dx_s), .dim_y(dy_s), .dim_z(dz_s), .blk(blk_s), .halo(halo_s),
    .step(step), .nbx(nbx), .nby(nby), .total(total_c)
  );

  tile_walker #(.DIM_W(DIM_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(accept_start), .adv(fire),
    .blk(blk_s), .halo(halo_s), .step(step), .nbx(nbx), .nby(nby),
    .dim_z(dz_s), .gx(gx), .gy(gy), .gz(gz), .lx(lx)
  );

  addr_map #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_map (
    .gx(gx), .gy(gy), .gz(gz), .dim_x(dx_q), .dim_y(dy_q), .pad(pad_q),
    .addr(out_addr), .oob(out_oob)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0; done_q <= 1'b0; idx <= '0; total_q <= '0;
      dx_q <= '0; dy_q <= '0; dz_q <= '0; blk_q <= '0; halo_q <= '0; pad_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_start) begin
        dx_q <= dim_x; dy_q <= dim_y; dz_q <= dim_z;
        blk_q <= blk_size; halo_q <= halo; pad_q <= pad;
        total_q <= total_c;
        idx     <= '0;
        if (total_c == '0) done_q  <= 1'b1;
        else               running <= 1'b1;
      end else if (fire) begin
        idx <= idx + CNT_W'(1);
        if (last_fire) begin
          running <= 1'b0;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign out_valid = running;
  assign done      = done_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_oob));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && start |=> $stable(total_q) && $stable(pad_q) && $stable(dx_q));

  assert_local_x_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lx < blk_q);

  assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> idx < total_q);

  assert_first_corner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start && total_c != '0 |=> gx == -$signed({2'b00, halo_q}) && gz == '0);
endmodule

// File: tb/tile_addr_gen_tb.sv
module tile_addr_gen_tb;
  localparam int DIM_W = 12, ADDR_W = 32, CNT_W = 40;

  logic clk = 0, rst_n = 0, start = 0, out_ready = 1;
  logic [DIM_W-1:0] dim_x = 0, dim_y = 0, dim_z = 0, blk_size = 0, halo = 0;
  logic [ADDR_W-1:0] pad = 0;
  logic out_valid, out_oob, done;
  logic [ADDR_W-1:0] out_addr;

  always #10 clk = ~clk;

  tile_addr_gen #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dim_x(dim_x), .dim_y(dim_y),
    .dim_z(dim_z), .blk_size(blk_size), .halo(halo), .pad(pad),
    .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr),
    .out_oob(out_oob), .done(done)
  );

  int checks = 0, fails = 0;
  logic [ADDR_W:0] sb[$];
  int  rmode = 0;
  logic [7:0] lf = 8'h5a;
  int  out_cnt = 0, done_cnt = 0;
  logic held_v = 0, prev_fire = 0, prev_start = 0;
  logic [ADDR_W:0] held;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Ready pattern generator
  always @(posedge clk) begin
    #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    case (rmode)
      1: out_ready = lf[0] | lf[2];
      2: out_ready = ~out_ready;
      default: out_ready = 1'b1;
    endcase
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_v)
        chk(out_valid && {out_oob, out_addr} == held, "R8 stall hold",
            longint'({out_oob, out_addr}), longint'(held));
      if (done) begin
        chk(!out_valid, "R9 valid low with done", longint'(out_valid), 0);
        chk(prev_fire || prev_start, "R9 done follows last accept", 0, 1);
        done_cnt++;
      end
      if (out_valid && out_ready) begin
        out_cnt++;
        if (sb.size() == 0)
          chk(0, "R7 extra access", longint'(out_addr), -1);
        else begin
          logic [ADDR_W:0] e;
          e = sb.pop_front();
          chk({out_oob, out_addr} == e, "R2 R3 R5 R6 access",
              longint'({out_oob, out_addr}), longint'(e));
        end
      end
      held_v     = out_valid && !out_ready;
      held       = {out_oob, out_addr};
      prev_fire  = out_valid && out_ready;
      prev_start = start;
    end
  end

  // Expected sweep, computed from the requirements; returns the access count.
  task automatic push_expected(input int dx, dy, dz, b, h, p, output int n);
    int step, nbx, nby;
    n = 0;
    step = b - 2 * h;
    nbx = 0; nby = 0;
    if (step > 0) begin
      for (int s = 0; s < dx; s += step) nbx++;
      for (int s = 0; s < dy; s += step) nby++;
    end
    for (int ty = 0; ty < nby; ty++)
      for (int tx = 0; tx < nbx; tx++)
        for (int z = 0; z < dz; z++)
          for (int y = 0; y < b; y++)
            for (int x = 0; x < b; x++) begin
              int cx, cy;
              bit o;
              longint a;
              cx = tx * step - h + x;  // R4 tile origin
              cy = ty * step - h + y;
              o = (cx < 0) || (cx >= dx) || (cy < 0) || (cy >= dy);
              a = o ? 0 : longint'(p) + (longint'(z) * dy + cy) * dx + cx;
              sb.push_back({o, a[ADDR_W-1:0]});
              n++;
            end
  endtask

  task automatic run_case(input int dx, dy, dz, b, h, p, md, input bit busy_start);
    int n, d0, t;
    push_expected(dx, dy, dz, b, h, p, n);
    @(posedge clk); #2;
    rmode = md;
    dim_x = DIM_W'(dx); dim_y = DIM_W'(dy); dim_z = DIM_W'(dz);
    blk_size = DIM_W'(b); halo = DIM_W'(h); pad = ADDR_W'(p);
    out_cnt = 0; d0 = done_cnt;
    start = 1;
    @(posedge clk); #2;
    start = 0;
    if (busy_start) begin
      repeat (20) @(posedge clk);
      #2;
      dim_x = 3; dim_y = 3; dim_z = 1; blk_size = 3; halo = 0; pad = 7;
      start = 1;  // R10: must be ignored mid-run
      @(posedge clk); #2;
      start = 0;
    end
    t = 0;
    while (done_cnt == d0 && t < 20000) begin
      @(posedge clk); t++;
    end
    chk(done_cnt == d0 + 1, "R9 done pulse seen", done_cnt - d0, 1);
    @(negedge clk);
    chk(out_cnt == n, "R7 access count", out_cnt, n);
    chk(sb.size() == 0, "R7 scoreboard drained", sb.size(), 0);
    chk(!done, "R9 single-cycle done", longint'(done), 0);
    if (busy_start) chk(out_cnt == n, "R10 busy start ignored", out_cnt, n);
    if (n == 0) chk(out_cnt == 0, "R11 zero total emits nothing", out_cnt, 0);
    sb.delete();
  endtask

  bit finished = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !done, "R1 reset outputs", longint'({out_valid, done}), 0);
    #5 rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !done, "R1 idle after reset", longint'({out_valid, done}), 0);
    run_case(10, 7, 2, 6, 1, 16, 0, 0);   // partial tiles, step 4
    run_case(10, 7, 2, 6, 1, 16, 1, 1);   // stalls + mid-run start
    run_case(8, 8, 1, 4, 0, 0, 2, 0);     // R4 step equals block, no overlap
    run_case(5, 3, 3, 8, 2, 32, 1, 0);    // one tile wider than grid
    run_case(13, 5, 1, 5, 1, 48, 2, 0);   // step 3, ragged edge
    run_case(6, 6, 0, 4, 1, 0, 0, 0);     // R11 zero planes
    run_case(6, 6, 2, 2, 1, 0, 0, 0);     // R11 block too small for halo
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule